// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

This block controls an 8-bit general-purpose I/O port. Every pin carries six configuration bits held in byte registers: direction, output level, reduced drive, pull enable, polarity and interrupt enable. From these bits the block computes the pad-control lines: output enable, output value, reduced-drive select, pull-up enable and pull-down enable. The polarity bit does two jobs. It picks which pull device is used, and it picks which edge raises an interrupt.

Pad inputs pass through a two-flop synchronizer. The synchronized levels feed an edge detector, which sets sticky per-pin flags. Software clears a flag by writing a 1 to its bit. One interrupt line is the OR of every flag that is still enabled. Edge detection keeps running while a pin drives its pad, because the detector watches the pad level, not the output register.

Software reaches the block through a simple synchronous bus. A write takes effect at the clock edge. A read returns its data on `bus_rdata` one cycle later, and `bus_rdata` holds that value until the next read.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, all configuration bits and flags are 0. `pad_oe`, `pad_out`, `pad_rdrv`, `pad_pu`, `pad_pd` and `irq` are all 0.
- R2: When a pin's direction bit is 1, `pad_oe` is 1 and `pad_out` equals its output-level bit. When the direction bit is 0, both `pad_oe` and `pad_out` are 0.
- R3: For an input pin with pull enable 1, polarity 0 sets `pad_pu` and polarity 1 sets `pad_pd`. With pull enable 0, neither is set. The two are never both 1.
- R4: For an output pin, `pad_pu` and `pad_pd` are 0 whatever the pull-enable and polarity bits hold.
- R5: `pad_rdrv` equals the reduced-drive bit for an output pin and is 0 for an input pin.
- R6: With interrupt enable 1, polarity 0 arms falling-edge detection and polarity 1 arms rising-edge detection on the synchronized pad level. A matching edge sets the pin's flag on the third clock edge after the pad changes. With interrupt enable 0, no flag is set.
- R7: Edge detection works the same way on output pins, using the pad input level.
- R8: Flags are sticky. A write to the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: `irq` is 1 exactly when some pin has both its flag and its interrupt enable set.
- R10: A read of the data register returns, for each pin, the output-level bit if the pin is an output and the synchronized pad level if it is an input.
- R11: The register offsets are: 0 data/output level, 1 direction, 2 reduced drive, 3 pull enable, 4 polarity, 5 interrupt enable, 6 flags. Offset 7 reads 0. Read data appears on `bus_rdata` one cycle after the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_rdrv | output | 8 | Reduced-drive select |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume three things about the inputs:
- `rst_n` is held low for at least one clock edge before use.
- `bus_addr`, `bus_we` and `bus_wdata` are stable at the clock edge whenever `bus_en` is high.
- `pad_in` may change at any time, because it is synchronized.

The stimulus drives the bus and the pads only at falling clock edges, with one access per strobe. Each pad change is followed by at least five clocks before a flag is read, which lets the synchronizer and detector settle. Configurations, pad levels and flag-clear masks are drawn from a fixed-seed random stream.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_rdrv,
  output logic [W-1:0]  pad_pu,
  output logic [W-1:0]  pad_pd,
  output logic          irq
);
  localparam logic [AW-1:0] A_LVL  = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_RDRV = AW'(2);
  localparam logic [AW-1:0] A_PEN  = AW'(3);
  localparam logic [AW-1:0] A_POL  = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_FLG  = AW'(6);

  logic [W-1:0] lvl_q, dir_q, rdrv_q, pen_q, pol_q, ien_q, flag_q;
  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] rise, fall, hit, clr, rmux;
  logic         wr, rd;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      dir_q  <= '0;
      rdrv_q <= '0;
      pen_q  <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_LVL:   lvl_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_RDRV:  rdrv_q <= bus_wdata;
        A_PEN:   pen_q  <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign hit  = ien_q & ((pol_q & rise) | (~pol_q & fall));
  assign clr  = (wr && bus_addr == A_FLG) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | hit;
  end

  assign irq = |(flag_q & ien_q);

  assign pad_oe   = dir_q;
  assign pad_out  = dir_q & lvl_q;
  assign pad_rdrv = dir_q & rdrv_q;
  assign pad_pu   = ~dir_q & pen_q & ~pol_q;
  assign pad_pd   = ~dir_q & pen_q & pol_q;

  always_comb begin
    case (bus_addr)
      A_LVL:   rmux = (dir_q & lvl_q) | (~dir_q & sync2_q);
      A_DIR:   rmux = dir_q;
      A_RDRV:  rmux = rdrv_q;
      A_PEN:   rmux = pen_q;
      A_POL:   rmux = pol_q;
      A_IEN:   rmux = ien_q;
      A_FLG:   rmux = flag_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rmux;
  end
endmodule

module gpio_edge_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_pu,
  input logic [W-1:0]  pad_pd,
  input logic [W-1:0]  flag_q,
  input logic [W-1:0]  ien_q,
  input logic          irq
);
  p_pull_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  p_out_no_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & (pad_pu | pad_pd)) == '0);

  p_no_set_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ien_q)) == '0));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && bus_addr == AW'(6)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .flag_q(flag_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_en = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_oe, pad_out, pad_rdrv, pad_pu, pad_pd;
  logic       irq;
  int         checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_rdrv(pad_rdrv), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq)
  );

  function automatic logic [7:0] f_pu(logic [7:0] d, logic [7:0] pe, logic [7:0] p);
    return ~d & pe & ~p;
  endfunction
  function automatic logic [7:0] f_pd(logic [7:0] d, logic [7:0] pe, logic [7:0] p);
    return ~d & pe & p;
  endfunction
  function automatic logic [7:0] f_hit(logic [7:0] o, logic [7:0] n, logic [7:0] ie, logic [7:0] p);
    return ie & ((p & n & ~o) | (~p & ~n & o));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, d, lv, rdv, pe, p, ie, o, n, ef, m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pad_oe == 0 && pad_out == 0 && pad_rdrv == 0, "R1 drive", pad_oe | pad_out | pad_rdrv, 8'h00);
    chk(pad_pu == 0 && pad_pd == 0 && irq == 0, "R1 pull/irq", pad_pu | pad_pd, 8'h00);
    for (int a = 1; a < 7; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 reg zero", v, 8'h00);
    end
    // R11 map readback and unused offset
    wr(3'd1, 8'h11); wr(3'd2, 8'h22); wr(3'd3, 8'h33); wr(3'd4, 8'h44); wr(3'd5, 8'h00);
    rd(3'd1, v); chk(v == 8'h11, "R11 dir", v, 8'h11);
    rd(3'd2, v); chk(v == 8'h22, "R11 rdrv", v, 8'h22);
    rd(3'd3, v); chk(v == 8'h33, "R11 pen", v, 8'h33);
    rd(3'd4, v); chk(v == 8'h44, "R11 pol", v, 8'h44);
    rd(3'd7, v); chk(v == 8'h00, "R11 offset7", v, 8'h00);
    repeat (3) @(negedge clk);
    chk(bus_rdata == 8'h00, "R11 hold", bus_rdata, 8'h00);
    // R8 write-1-clear: arm rising on all, raise all pads
    wr(3'd1, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pad_in = 8'h00; settle(); wr(3'd6, 8'hFF);
    pad_in = 8'hFF; settle();
    rd(3'd6, v); chk(v == 8'hFF, "R6 all rising", v, 8'hFF);
    wr(3'd6, 8'h00); rd(3'd6, v); chk(v == 8'hFF, "R8 write0 no effect", v, 8'hFF);
    wr(3'd6, 8'hA5); rd(3'd6, v); chk(v == 8'h5A, "R8 partial clear", v, 8'h5A);
    chk(irq == 1, "R9 irq set", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'hA5); @(negedge clk);
    chk(irq == 0, "R9 irq masked", {7'd0, irq}, 8'h00);
    rd(3'd6, v); chk(v == 8'h5A, "R8 flags kept when masked", v, 8'h5A);
    wr(3'd6, 8'hFF);
    // random trials
    for (int t = 0; t < 60; t++) begin
      d = 8'($urandom); lv = 8'($urandom); rdv = 8'($urandom);
      pe = 8'($urandom); p = 8'($urandom); ie = 8'($urandom);
      o = 8'($urandom); n = 8'($urandom);
      if (t < 4) begin d = (t % 2 == 0) ? 8'hFF : 8'h00; ie = 8'hFF; end
      wr(3'd0, lv); wr(3'd1, d); wr(3'd2, rdv); wr(3'd3, pe); wr(3'd4, p); wr(3'd5, ie);
      pad_in = o; settle(); wr(3'd6, 8'hFF);
      rd(3'd6, v); chk(v == 0, "R8 cleared", v, 8'h00);
      chk(pad_oe == d, "R2 oe", pad_oe, d);
      chk(pad_out == (d & lv), "R2 out", pad_out, d & lv);
      chk(pad_pu == f_pu(d, pe, p), "R3 pu", pad_pu, f_pu(d, pe, p));
      chk(pad_pd == f_pd(d, pe, p), "R3 pd", pad_pd, f_pd(d, pe, p));
      chk(((pad_pu | pad_pd) & d) == 0, "R4 output no pull", (pad_pu | pad_pd) & d, 8'h00);
      chk(pad_rdrv == (d & rdv), "R5 rdrv", pad_rdrv, d & rdv);
      rd(3'd0, v); chk(v == ((d & lv) | (~d & o)), "R10 data", v, (d & lv) | (~d & o));
      pad_in = n; settle();
      ef = f_hit(o, n, ie, p);
      rd(3'd6, v);
      chk((v & ~d) == (ef & ~d), "R6 input edge", v & ~d, ef & ~d);
      chk((v & d) == (ef & d), "R7 output edge", v & d, ef & d);
      chk(irq == (ef != 0), "R9 irq", {7'd0, irq}, {7'd0, ef != 0});
      m = 8'($urandom);
      wr(3'd6, m); rd(3'd6, v);
      chk(v == (ef & ~m), "R8 random clear", v, ef & ~m);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule